// File: doc/BRIEF.md
# Fixed Resource Allocation Capability Register File

This block is the register file for a configuration-space capability that tells system software which fixed address ranges a function owns. Software reads and writes it one 32-bit doubleword at a time, using a doubleword offset relative to the start of the capability. Every field is decoded with its own access type: read-only, hardware-initialised, read-write, or reserved. Write byte enables are applied lane by lane.

The structure begins with a header doubleword. For a bridge function, a second doubleword follows that carries the fixed bus-number window. After that comes a packed list of resource entries. Each entry has one header doubleword, then a base field and an extent field. The base and the extent are each either 32 or 64 bits wide, so an entry is three, four or five doublewords long. All entry properties are set by elaboration parameters, and the offset at which each entry starts is computed from them.

Address-range decoding and walking the capability list are handled elsewhere. This block only stores the fields and returns them.

Top module: `rescap_regs`

## Requirements
- R1: Offset 0 reads as follows: the capability ID 14h in bits 7:0, the next-capability pointer in bits 15:8, the number of entries in bits 21:16 (zero is allowed), and zero in bits 31:22.
- R2: When the function is a bridge, offset 1 reads the fixed secondary bus number in bits 7:0, the fixed subordinate bus number in bits 15:8, and zero in bits 31:16. Entries start at offset 2 for a bridge and at offset 1 otherwise.
- R3: Entries follow one another with no gaps. An entry header reads as follows:
  - bits 2:0: the number of doublewords that follow the header;
  - bits 7:4: the BAR-equivalent index;
  - bits 15:8: the primary property code;
  - bits 23:16: the secondary property code;
  - bit 30: the writable flag;
  - bit 31: the enable flag;
  - bit 3 and bits 29:24: zero.
- R4: After the entry header come, in this order:
  - the base low doubleword;
  - the base high doubleword, only if the base is 64-bit;
  - the extent low doubleword;
  - the extent high doubleword, only if the extent is 64-bit.
  In each low doubleword, bits 31:2 carry the address, bit 1 is the field size (1 means 64-bit), and bit 0 reads zero.
- R5: In an entry whose writable flag is 1, a write updates bits 31:2 of the base and extent low doublewords and all bits of their high doublewords. The size bit and bit 0 keep their values.
- R6: In an entry whose writable flag is 0, writes to the base and extent doublewords have no effect.
- R7: The enable flag, bit 31 of the entry header, can be written only in entries built with a read-write enable. In other entries it keeps its built-in value.
- R8: A write changes only the byte lanes whose byte enable is set (enable bit n covers data bits 8n+7:8n), and within those lanes only the writable bits.
- R9: A read at any offset past the last doubleword of the last entry returns zero, and a write there has no effect.
- R10: Read data is registered:
  - it changes on the clock edge at which the read strobe is sampled;
  - it holds between reads;
  - it is zero after reset;
  - reset restores every writable field to its built-in value.
- R11: Writes to the header doubleword, the bus-number doubleword, and the read-only bits of an entry header have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr | input | ADDR_W | Doubleword offset within the capability |
| cfg_rd | input | 1 | Read strobe, one cycle per read |
| cfg_wr | input | 1 | Write strobe, one cycle per write |
| cfg_wdata | input | 32 | Write data |
| cfg_be | input | 4 | Write byte enables, bit n covers data bits 8n+7:8n |
| cfg_rdata | output | 32 | Registered read data |

## Verification
The block's state is the set of writable base, extent and enable bits. A corrupted bit cannot show at the ports until software reads that doubleword, and it then appears in the read data one clock after the read strobe. The bench therefore reads back after every write and compares the whole doubleword. That comparison catches both a lost write and a write that leaked into read-only or reserved bits or into an unselected byte lane. An offset computed wrongly shifts every later entry, so the first read of any later doubleword shows the error.

// File: rtl/rescap_pkg.sv
// Shared constants and helpers for the fixed-resource capability register file.
// Assumes 32-bit configuration doublewords with four byte lanes.
package rescap_pkg;

    localparam logic [7:0] CAP_ID = 8'h14;

    typedef logic [31:0] dword_t;

    // Expand the four byte enables into a 32-bit lane mask.
    function automatic dword_t lane_mask(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

endpackage

// File: rtl/rescap_hdr.sv
// Read-only leading doublewords of the capability: the header and, for a
// bridge, the fixed bus-number window. Contains no storage; all values come
// from parameters. Assumes the caller registers the read data.
module rescap_hdr
    import rescap_pkg::*;
#(
    parameter int         AW      = 6,
    parameter int         NUM_ENT = 3,
    parameter bit         BRIDGE  = 1'b1,
    parameter logic [7:0] NXT_PTR = 8'h00,
    parameter logic [7:0] SEC_BUS = 8'h00,
    parameter logic [7:0] SUB_BUS = 8'h00
) (
    input  logic [AW-1:0] addr,
    output dword_t        word
);

    localparam dword_t HDR_WORD = {10'b0, 6'(NUM_ENT), NXT_PTR, CAP_ID};
    localparam dword_t BUS_WORD = {16'b0, SUB_BUS, SEC_BUS};

    // Select the header or bus-number word, or zero for any other offset.
    always_comb begin
        if (addr == '0)
            word = HDR_WORD;
        else if (BRIDGE && (addr == AW'(1)))
            word = BUS_WORD;
        else
            word = '0;
    end

endmodule

// File: rtl/rescap_entry.sv
// One resource entry: a header doubleword, then base and extent fields of
// 32 or 64 bits each. Write masks come from the per-entry parameters, so
// hardware-initialised bits keep their reset values. The output is zero when
// the offset is outside this entry. Assumes reads and writes share cfg addr.
module rescap_entry
    import rescap_pkg::*;
#(
    parameter int          AW       = 6,
    parameter int          OFS      = 2,
    parameter bit          B64      = 1'b0,
    parameter bit          X64      = 1'b0,
    parameter bit          WRITABLE = 1'b0,
    parameter bit          EN_RW    = 1'b0,
    parameter bit          EN_INIT  = 1'b1,
    parameter logic [3:0]  BAR_EQ   = 4'h7,
    parameter logic [7:0]  PRI_PROP = 8'h00,
    parameter logic [7:0]  SEC_PROP = 8'hFF,
    parameter logic [63:0] BASE0    = 64'h0,
    parameter logic [63:0] EXT0     = 64'h0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  dword_t        wdata,
    input  logic [3:0]    wbe,
    output dword_t        word
);

    localparam int          FOLLOW  = 2 + int'(B64) + int'(X64);
    localparam logic [2:0]  SIZE    = 3'(FOLLOW);
    localparam logic [AW-1:0] FIRST = AW'(OFS);
    localparam logic [AW-1:0] LAST  = AW'(OFS + FOLLOW);
    // Relative slot numbers; 7 is never reached and marks an absent slot.
    localparam logic [2:0]  S_BLO   = 3'd1;
    localparam logic [2:0]  S_BHI   = B64 ? 3'd2 : 3'd7;
    localparam logic [2:0]  S_XLO   = 3'(2 + int'(B64));
    localparam logic [2:0]  S_XHI   = X64 ? 3'(3 + int'(B64)) : 3'd7;
    localparam logic [29:0] LO_WM   = {30{WRITABLE}};
    localparam logic [31:0] BHI_WM  = {32{WRITABLE & B64}};
    localparam logic [31:0] XHI_WM  = {32{WRITABLE & X64}};

    logic        hit;
    logic [2:0]  rel;
    dword_t      bm;
    logic [29:0] base_lo_q, ext_lo_q;
    logic [31:0] base_hi_q, ext_hi_q;
    logic        en_q;

    // Decode whether the offset falls in this entry, and which slot.
    assign hit = (addr >= FIRST) && (addr <= LAST);
    assign rel = 3'(addr - FIRST);
    assign bm  = lane_mask(wbe);

    // Field storage; merge only the enabled lanes of the writable bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= EN_INIT;
            base_lo_q <= BASE0[31:2];
            base_hi_q <= B64 ? BASE0[63:32] : 32'h0;
            ext_lo_q  <= EXT0[31:2];
            ext_hi_q  <= X64 ? EXT0[63:32] : 32'h0;
        end else if (wr_en && hit) begin
            if ((rel == 3'd0) && EN_RW && wbe[3])
                en_q <= wdata[31];
            if (rel == S_BLO)
                base_lo_q <= (base_lo_q & ~(bm[31:2] & LO_WM)) | (wdata[31:2] & bm[31:2] & LO_WM);
            if (rel == S_BHI)
                base_hi_q <= (base_hi_q & ~(bm & BHI_WM)) | (wdata & bm & BHI_WM);
            if (rel == S_XLO)
                ext_lo_q <= (ext_lo_q & ~(bm[31:2] & LO_WM)) | (wdata[31:2] & bm[31:2] & LO_WM);
            if (rel == S_XHI)
                ext_hi_q <= (ext_hi_q & ~(bm & XHI_WM)) | (wdata & bm & XHI_WM);
        end
    end

    // Assemble the addressed doubleword with size bits and reserved zeros.
    always_comb begin
        word = '0;
        if (hit) begin
            if (rel == 3'd0)
                word = {en_q, WRITABLE, 6'b0, SEC_PROP, PRI_PROP, BAR_EQ, 1'b0, SIZE};
            else if (rel == S_BLO)
                word = {base_lo_q, B64, 1'b0};
            else if (rel == S_BHI)
                word = base_hi_q;
            else if (rel == S_XLO)
                word = {ext_lo_q, X64, 1'b0};
            else if (rel == S_XHI)
                word = ext_hi_q;
        end
    end

endmodule

// File: rtl/rescap_regs.sv
// Top of the fixed-resource capability register file. Places the header
// words and a generated list of entries at offsets computed from the
// per-entry size parameters, ORs their read words and registers the result.
// Assumes cfg_rd and cfg_wr are single-cycle strobes and never both high.
// Per-entry parameter vectors are indexed by entry number (bit i = entry i).
module rescap_regs
    import rescap_pkg::*;
#(
    parameter int                     ADDR_W   = 6,
    parameter int                     NUM_ENT  = 3,
    parameter bit                     IS_BRIDGE = 1'b1,
    parameter logic [7:0]             NXT_PTR  = 8'h50,
    parameter logic [7:0]             SEC_BUS  = 8'h05,
    parameter logic [7:0]             SUB_BUS  = 8'h07,
    parameter bit [NUM_ENT-1:0]       ENT_B64  = 3'b010,
    parameter bit [NUM_ENT-1:0]       ENT_X64  = 3'b100,
    parameter bit [NUM_ENT-1:0]       ENT_WR   = 3'b110,
    parameter bit [NUM_ENT-1:0]       ENT_ENRW = 3'b010,
    parameter bit [NUM_ENT-1:0]       ENT_EN0  = 3'b101,
    parameter logic [NUM_ENT*4-1:0]   ENT_BAR  = 12'h720,
    parameter logic [NUM_ENT*8-1:0]   ENT_PRI  = 24'h02_01_00,
    parameter logic [NUM_ENT*8-1:0]   ENT_SEC  = 24'hFF_00_FF,
    parameter logic [NUM_ENT*64-1:0]  ENT_BASE = {64'h0000_0000_0000_1000,
                                                  64'h0000_0001_0000_0000,
                                                  64'h0000_0000_F000_0000},
    parameter logic [NUM_ENT*64-1:0]  ENT_EXT  = {64'h0000_0002_0000_00FF,
                                                  64'h0000_0000_0000_FFFF,
                                                  64'h0000_0000_0000_0FFF}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_rd,
    input  logic              cfg_wr,
    input  logic [31:0]       cfg_wdata,
    input  logic [3:0]        cfg_be,
    output logic [31:0]       cfg_rdata
);

    // Start offset of entry i: leading words plus the lengths of earlier entries.
    function automatic int ofs_of(input int i);
        int o;
        o = 1 + int'(IS_BRIDGE);
        for (int k = 0; k < i; k++)
            o += 3 + int'(ENT_B64[k]) + int'(ENT_X64[k]);
        return o;
    endfunction

    localparam int END_OFS = ofs_of(NUM_ENT);

    dword_t hdr_word;
    dword_t ent_word [NUM_ENT];
    dword_t rd_word;
    dword_t rdata_q;

    rescap_hdr #(
        .AW(ADDR_W), .NUM_ENT(NUM_ENT), .BRIDGE(IS_BRIDGE),
        .NXT_PTR(NXT_PTR), .SEC_BUS(SEC_BUS), .SUB_BUS(SUB_BUS)
    ) u_hdr (
        .addr(cfg_addr),
        .word(hdr_word)
    );

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
        rescap_entry #(
            .AW(ADDR_W), .OFS(ofs_of(i)),
            .B64(ENT_B64[i]), .X64(ENT_X64[i]),
            .WRITABLE(ENT_WR[i]), .EN_RW(ENT_ENRW[i]), .EN_INIT(ENT_EN0[i]),
            .BAR_EQ(ENT_BAR[4*i +: 4]),
            .PRI_PROP(ENT_PRI[8*i +: 8]), .SEC_PROP(ENT_SEC[8*i +: 8]),
            .BASE0(ENT_BASE[64*i +: 64]), .EXT0(ENT_EXT[64*i +: 64])
        ) u_ent (
            .clk(clk), .rst_n(rst_n), .addr(cfg_addr),
            .wr_en(cfg_wr), .wdata(cfg_wdata), .wbe(cfg_be),
            .word(ent_word[i])
        );
    end

    // Combine the words of all sources; at most one is non-zero.
    always_comb begin
        rd_word = hdr_word;
        for (int i = 0; i < NUM_ENT; i++)
            rd_word = rd_word | ent_word[i];
    end

    // Capture the addressed word when a read is strobed; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (cfg_rd)
            rdata_q <= rd_word;
    end

    assign cfg_rdata = rdata_q;

endmodule

// File: rtl/rescap_chk.sv
// Port-level properties of the capability register file, bound to the top.
module rescap_chk #(
    parameter int AW      = 6,
    parameter int END_OFS = 13,
    parameter int NUM_ENT = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] cfg_addr,
    input logic          cfg_rd,
    input logic [31:0]   cfg_rdata
);

    a_r1_header_word: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cfg_addr == '0) |=>
            (cfg_rdata[7:0] == 8'h14 && cfg_rdata[21:16] == 6'(NUM_ENT) && cfg_rdata[31:22] == '0))
        else $error("R1 header doubleword malformed");

    a_r9_past_end_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cfg_addr >= AW'(END_OFS)) |=> (cfg_rdata == '0))
        else $error("R9 read past last entry not zero");

    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd |=> $stable(cfg_rdata))
        else $error("R10 read data moved without a read");

    a_r10_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (cfg_rdata == '0))
        else $error("R10 read data not cleared by reset");

endmodule

bind rescap_regs rescap_chk #(
    .AW(ADDR_W), .END_OFS(END_OFS), .NUM_ENT(NUM_ENT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr),
    .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata)
);

// File: tb/sim_rescap_regs.sv
// Bench for rescap_regs with default parameters. Layout under test:
// 0 header, 1 bus numbers, entry0 at 2..4, entry1 at 5..8, entry2 at 9..12.
module sim_rescap_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic        cfg_rd = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    rescap_regs u0 (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rd(cfg_rd),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_be(cfg_be),
        .cfg_rdata(cfg_rdata)
    );

    typedef struct packed {
        logic        wr;
        logic [5:0]  addr;
        logic [31:0] data;
        logic [3:0]  be;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 6'd0,  32'h0,         4'h0, 32'h0003_5014, 4'd1},  // R1
        '{1'b0, 6'd1,  32'h0,         4'h0, 32'h0000_0705, 4'd2},  // R2
        '{1'b0, 6'd2,  32'h0,         4'h0, 32'h80FF_0002, 4'd3},  // R3
        '{1'b0, 6'd3,  32'h0,         4'h0, 32'hF000_0000, 4'd4},  // R4
        '{1'b0, 6'd4,  32'h0,         4'h0, 32'h0000_0FFC, 4'd4},  // R4
        '{1'b0, 6'd5,  32'h0,         4'h0, 32'h4000_0123, 4'd3},  // R3
        '{1'b0, 6'd6,  32'h0,         4'h0, 32'h0000_0002, 4'd4},  // R4
        '{1'b0, 6'd7,  32'h0,         4'h0, 32'h0000_0001, 4'd4},  // R4
        '{1'b0, 6'd8,  32'h0,         4'h0, 32'h0000_FFFC, 4'd4},  // R4
        '{1'b0, 6'd9,  32'h0,         4'h0, 32'hC0FF_0273, 4'd3},  // R3
        '{1'b0, 6'd10, 32'h0,         4'h0, 32'h0000_1000, 4'd4},  // R4
        '{1'b0, 6'd11, 32'h0,         4'h0, 32'h0000_00FE, 4'd4},  // R4
        '{1'b0, 6'd12, 32'h0,         4'h0, 32'h0000_0002, 4'd4},  // R4
        '{1'b0, 6'd13, 32'h0,         4'h0, 32'h0000_0000, 4'd9},  // R9
        '{1'b0, 6'd63, 32'h0,         4'h0, 32'h0000_0000, 4'd9},  // R9
        '{1'b1, 6'd0,  32'hFFFF_FFFF, 4'hF, 32'h0003_5014, 4'd11}, // R11
        '{1'b1, 6'd1,  32'hFFFF_FFFF, 4'hF, 32'h0000_0705, 4'd11}, // R11
        '{1'b1, 6'd3,  32'hFFFF_FFFF, 4'hF, 32'hF000_0000, 4'd6},  // R6
        '{1'b1, 6'd4,  32'h0000_0000, 4'hF, 32'h0000_0FFC, 4'd6},  // R6
        '{1'b1, 6'd2,  32'h0000_0000, 4'hF, 32'h80FF_0002, 4'd7},  // R7
        '{1'b1, 6'd6,  32'h1234_5679, 4'hF, 32'h1234_567A, 4'd5},  // R5
        '{1'b1, 6'd7,  32'hAABB_CCDD, 4'h5, 32'h00BB_00DD, 4'd8},  // R8
        '{1'b1, 6'd8,  32'hFFFF_FFFF, 4'h8, 32'hFF00_FFFC, 4'd8},  // R8
        '{1'b1, 6'd5,  32'h8000_0000, 4'h8, 32'hC000_0123, 4'd7},  // R7
        '{1'b1, 6'd5,  32'h0000_0000, 4'h7, 32'hC000_0123, 4'd8},  // R8
        '{1'b1, 6'd5,  32'h0000_0000, 4'h8, 32'h4000_0123, 4'd7},  // R7
        '{1'b1, 6'd5,  32'hFFFF_FFFF, 4'hF, 32'hC000_0123, 4'd11}, // R11
        '{1'b1, 6'd9,  32'h0000_0000, 4'hF, 32'hC0FF_0273, 4'd7},  // R7
        '{1'b1, 6'd12, 32'hDEAD_BEEF, 4'hF, 32'hDEAD_BEEF, 4'd5},  // R5
        '{1'b1, 6'd11, 32'h0000_0001, 4'hF, 32'h0000_0002, 4'd5},  // R5
        '{1'b1, 6'd13, 32'hFFFF_FFFF, 4'hF, 32'h0000_0000, 4'd9},  // R9
        '{1'b1, 6'd10, 32'hFFFF_FFFF, 4'h3, 32'h0000_FFFC, 4'd8}   // R8
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    task automatic do_rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        cfg_addr = a;
        cfg_rd   = 1'b1;
        @(negedge clk);
        cfg_rd   = 1'b0;
        v = cfg_rdata;
    endtask

    task automatic do_wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        cfg_addr  = a;
        cfg_wdata = d;
        cfg_be    = be;
        cfg_wr    = 1'b1;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: read data is zero straight after reset
        check(10, cfg_rdata, 32'h0, "reset read data");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr)
                do_wr(VEC[i].addr, VEC[i].data, VEC[i].be);
            do_rd(VEC[i].addr, v);
            check(int'(VEC[i].req), v, VEC[i].exp, $sformatf("vector %0d offset %0d", i, VEC[i].addr));
        end

        // R10: read data holds while no read is strobed
        do_rd(6'd0, v);
        @(negedge clk);
        cfg_addr = 6'd9;
        repeat (3) @(negedge clk);
        check(10, cfg_rdata, 32'h0003_5014, "hold between reads");

        // R10: reset restores writable fields to built-in values
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(10, cfg_rdata, 32'h0, "read data cleared by reset");
        rst_n = 1'b1;
        do_rd(6'd6, v);
        check(10, v, 32'h0000_0002, "base low restored");
        do_rd(6'd7, v);
        check(10, v, 32'h0000_0001, "base high restored");
        do_rd(6'd5, v);
        check(10, v, 32'h4000_0123, "enable restored");
        do_rd(6'd12, v);
        check(10, v, 32'h0000_0002, "extent high restored");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule